// File: doc/BRIEF.md
# Frame Timing Sequencer with Divided Row Clock

This block generates a repeating frame of control strobes for a sensor readout chain. It counts rising edges of a base shift clock, nominally 250 kHz, in a single frame counter. The strobes are decoded from that counter: a row-driver enable, an integrate pulse, an output-phase pulse for an integrate-and-fire front end, and an active-low ADC chip select that frames a contiguous read window of one sample per base cycle. Windows start at fixed offsets and have fixed lengths, set by parameters.

The shift clock enters on `sclk_i`. When it comes from off-chip, a configurable synchronizer brings it into the system clock domain. A rising-edge detector then turns it into a single-cycle tick, and only that tick advances the counter. The frame length is a programmable terminal count. The block also divides the base clock into a much slower row-driver clock, which toggles every programmed number of base cycles. This clock starts running as soon as the sequencer is enabled, so the row driver receives its warm-up cycles well before the first row enable.

All outputs are registered and change only in the system cycle that carries a detected edge. While `run_i` is low, the counter is cleared and every output stays in its inactive state.

Top module: `fts_sequencer`

## Requirements
- R1: After reset, row enable, integrate and output-phase are 0, the ADC chip select is 1 and the row clock is 0, and no output changes while `run_i` is 0.
- R2: The frame count advances by exactly one per rising edge of `sclk_i`, however long `sclk_i` stays high. Edges seen while `run_i` is 0 are not counted. Outputs change only in a system cycle that carries a detected edge.
- R3: The row enable goes to 1 on the edge that brings the count to 100 and stays at 1 until the frame wraps.
- R4: The integrate output is 1 for counts 100 through 124, which is 25 base cycles.
- R5: The output-phase pulse is 1 for counts 125 through 129, which is 5 base cycles.
- R6: The ADC chip select is 0 for counts 125 through 156, which is 32 contiguous base cycles, and 1 at every other count.
- R7: On the edge after the count equals `frame_last_i`, the count returns to 0. All enables and pulses go to 0 and the chip select returns to 1.
- R8: The row clock inverts every Z counted edges, where Z is `row_div_i`, so after k edges it equals (k / Z) mod 2. A Z of 0 behaves as 1.
- R9: Dropping `run_i` clears the count and returns all outputs to the R1 state within one system cycle. Raising it again starts the frame from count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Sequencer enable; low holds idle state |
| sclk_i | input | 1 | Base shift clock whose rising edges are counted |
| frame_last_i | input | CW | Terminal count of a frame |
| row_div_i | input | DW | Base cycles per row-clock half period |
| row_en_o | output | 1 | Row-driver enable |
| integ_o | output | 1 | Integrate pulse |
| fire_out_o | output | 1 | Output-phase pulse to integrate-and-fire stage |
| adc_cs_n_o | output | 1 | Active-low ADC chip select |
| row_clk_o | output | 1 | Divided row-driver clock |

## Verification
The main frame is first walked across two full frames with a terminal count of 199 and a divider of 7. Outputs are sampled at each window boundary and one count on either side of it, which separates an off-by-one start from an off-by-one end for each strobe. The chip-select low time is also totalled across a whole frame to confirm it is exactly 32. A frame of 105 counts, with windows still open at the wrap, shows that the terminal count truncates the windows rather than leaving them to close on their own. A divider of 0 shows the clamp to 1. A shift-clock high phase held for many system cycles, together with edges supplied while disabled, shows that the count depends only on qualified rising edges.

// File: rtl/fts_pkg.sv
package fts_pkg;

  typedef struct packed {
    logic row_en;
    logic integ;
    logic fire_out;
    logic adc_cs_n;
  } strobes_t;

  localparam strobes_t STROBES_IDLE = '{row_en: 1'b0, integ: 1'b0, fire_out: 1'b0, adc_cs_n: 1'b1};

  // half-open window [start, start+len)
  function automatic logic in_window(input int unsigned c, input int unsigned start,
                                     input int unsigned len);
    return (c >= start) && (c < start + len);
  endfunction

  // window open from start until the frame wraps
  function automatic logic from_on(input int unsigned c, input int unsigned start);
    return c >= start;
  endfunction

  function automatic strobes_t decode_strobes(input int unsigned c,
                                              input int unsigned row_at,
                                              input int unsigned int_at, input int unsigned int_len,
                                              input int unsigned out_at, input int unsigned out_len,
                                              input int unsigned cs_at, input int unsigned cs_len);
    strobes_t s;
    s.row_en   = from_on(c, row_at);
    s.integ    = in_window(c, int_at, int_len);
    s.fire_out = in_window(c, out_at, out_len);
    s.adc_cs_n = ~in_window(c, cs_at, cs_len);
    return s;
  endfunction

  // divider limit: a zero ratio behaves as one
  function automatic int unsigned div_limit(input int unsigned ratio);
    return (ratio == 0) ? 0 : ratio - 1;
  endfunction

endpackage

// File: rtl/fts_edge_detect.sv
module fts_edge_detect #(
  parameter bit SCLK_ASYNC  = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  output logic tick_o
);
  logic sclk_s;
  logic sclk_prev;

  generate
    if (SCLK_ASYNC) begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], sclk_i};
      end
      assign sclk_s = sync_q[SYNC_STAGES-1];
    end else begin : g_direct
      assign sclk_s = sclk_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= sclk_s;
  end

  assign tick_o = sclk_s & ~sclk_prev;
endmodule

// File: rtl/fts_frame_ctr.sv
module fts_frame_ctr
  import fts_pkg::*;
#(
  parameter int CW      = 16,
  parameter int ROW_AT  = 100,
  parameter int INT_AT  = 100,
  parameter int INT_LEN = 25,
  parameter int OUT_AT  = 125,
  parameter int OUT_LEN = 5,
  parameter int CS_AT   = 125,
  parameter int CS_LEN  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [CW-1:0] last_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o,
  output strobes_t      strobes_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  strobes_t      strb_q;

  assign wrap_o  = run_i & tick_i & (cnt_q == last_i);
  assign cnt_nxt = (cnt_q == last_i) ? '0 : cnt_q + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      strb_q <= STROBES_IDLE;
    end else if (!run_i) begin
      cnt_q  <= '0;
      strb_q <= STROBES_IDLE;
    end else if (tick_i) begin
      cnt_q  <= cnt_nxt;
      strb_q <= decode_strobes(32'(cnt_nxt), ROW_AT, INT_AT, INT_LEN,
                               OUT_AT, OUT_LEN, CS_AT, CS_LEN);
    end
  end

  assign cnt_o     = cnt_q;
  assign strobes_o = strb_q;
endmodule

// File: rtl/fts_clk_div.sv
module fts_clk_div
  import fts_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [DW-1:0] ratio_i,
  output logic          div_clk_o,
  output logic          flip_o
);
  logic [DW-1:0] dcnt_q;
  logic [DW-1:0] limit;
  logic          dclk_q;

  assign limit  = DW'(div_limit(32'(ratio_i)));
  assign flip_o = run_i & tick_i & (dcnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q <= '0;
      dclk_q <= 1'b0;
    end else if (!run_i) begin
      dcnt_q <= '0;
      dclk_q <= 1'b0;
    end else if (tick_i) begin
      if (dcnt_q >= limit) begin
        dcnt_q <= '0;
        dclk_q <= ~dclk_q;
      end else begin
        dcnt_q <= dcnt_q + DW'(1);
      end
    end
  end

  assign div_clk_o = dclk_q;
endmodule

// File: rtl/fts_sequencer.sv
module fts_sequencer
  import fts_pkg::*;
#(
  parameter bit SCLK_ASYNC  = 1'b1,
  parameter int SYNC_STAGES = 2,
  parameter int CW          = 16,
  parameter int DW          = 16,
  parameter int ROW_AT      = 100,
  parameter int INT_AT      = 100,
  parameter int INT_LEN     = 25,
  parameter int OUT_AT      = 125,
  parameter int OUT_LEN     = 5,
  parameter int CS_AT       = 125,
  parameter int CS_LEN      = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          sclk_i,
  input  logic [CW-1:0] frame_last_i,
  input  logic [DW-1:0] row_div_i,
  output logic          row_en_o,
  output logic          integ_o,
  output logic          fire_out_o,
  output logic          adc_cs_n_o,
  output logic          row_clk_o
);
  // named internal events, visible to the checker
  logic          edge_tick;
  logic          frame_wrap;
  logic          row_flip;
  logic [CW-1:0] frame_cnt;
  strobes_t      strobes;

  fts_edge_detect #(.SCLK_ASYNC(SCLK_ASYNC), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .tick_o(edge_tick)
  );

  fts_frame_ctr #(
    .CW(CW), .ROW_AT(ROW_AT), .INT_AT(INT_AT), .INT_LEN(INT_LEN),
    .OUT_AT(OUT_AT), .OUT_LEN(OUT_LEN), .CS_AT(CS_AT), .CS_LEN(CS_LEN)
  ) u_frame (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .tick_i(edge_tick),
    .last_i(frame_last_i), .cnt_o(frame_cnt), .wrap_o(frame_wrap), .strobes_o(strobes)
  );

  fts_clk_div #(.DW(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .tick_i(edge_tick),
    .ratio_i(row_div_i), .div_clk_o(row_clk_o), .flip_o(row_flip)
  );

  assign row_en_o   = strobes.row_en;
  assign integ_o    = strobes.integ;
  assign fire_out_o = strobes.fire_out;
  assign adc_cs_n_o = strobes.adc_cs_n;
endmodule

// File: rtl/fts_sequencer_chk.sv
module fts_sequencer_chk #(
  parameter int CW      = 16,
  parameter int ROW_AT  = 100,
  parameter int INT_AT  = 100,
  parameter int INT_LEN = 25,
  parameter int OUT_AT  = 125,
  parameter int OUT_LEN = 5,
  parameter int CS_AT   = 125,
  parameter int CS_LEN  = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_i,
  input logic          edge_tick,
  input logic          frame_wrap,
  input logic          row_flip,
  input logic [CW-1:0] frame_cnt,
  input logic          row_en_o,
  input logic          integ_o,
  input logic          fire_out_o,
  input logic          adc_cs_n_o,
  input logic          row_clk_o
);
  // R1
  idle_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (frame_cnt == '0) && !row_en_o && !integ_o && !fire_out_o && adc_cs_n_o && !row_clk_o);

  // R2
  quiet_without_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !edge_tick) |=> $stable({row_en_o, integ_o, fire_out_o, adc_cs_n_o, row_clk_o, frame_cnt}));

  // R3
  row_en_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row_en_o) |-> 32'(frame_cnt) == ROW_AT);

  // R4
  integ_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(integ_o) |-> 32'(frame_cnt) == INT_AT);

  // R4
  integ_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(integ_o) |-> (32'(frame_cnt) == INT_AT + INT_LEN) || (frame_cnt == '0) || !$past(run_i));

  // R5
  fire_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fire_out_o) |-> 32'(frame_cnt) == OUT_AT);

  // R6
  cs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n_o) |-> 32'(frame_cnt) == CS_AT);

  // R6
  cs_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cs_n_o) |-> (32'(frame_cnt) == CS_AT + CS_LEN) || (frame_cnt == '0) || !$past(run_i));

  // R7
  wrap_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> (frame_cnt == '0) && !row_en_o && !integ_o && !fire_out_o && adc_cs_n_o);

  // R8
  row_clk_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_flip |=> row_clk_o != $past(row_clk_o));

  // R8
  row_clk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !row_flip) |=> $stable(row_clk_o));
endmodule

bind fts_sequencer fts_sequencer_chk #(
  .CW(CW), .ROW_AT(ROW_AT), .INT_AT(INT_AT), .INT_LEN(INT_LEN),
  .OUT_AT(OUT_AT), .OUT_LEN(OUT_LEN), .CS_AT(CS_AT), .CS_LEN(CS_LEN)
) chk_i (
  .clk(clk), .rst_n(rst_n), .run_i(run_i), .edge_tick(edge_tick),
  .frame_wrap(frame_wrap), .row_flip(row_flip), .frame_cnt(frame_cnt),
  .row_en_o(row_en_o), .integ_o(integ_o), .fire_out_o(fire_out_o),
  .adc_cs_n_o(adc_cs_n_o), .row_clk_o(row_clk_o)
);

// File: tb/fts_sequencer_tb.sv
`timescale 1ns/1ps
module fts_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_i = 1'b0;
  logic        sclk_i = 1'b0;
  logic [15:0] frame_last_i = 16'd199;
  logic [15:0] row_div_i = 16'd7;
  logic        row_en_o, integ_o, fire_out_o, adc_cs_n_o, row_clk_o;

  int total = 0;
  int bad   = 0;
  int edges = 0;
  int zdiv  = 7;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  fts_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .sclk_i(sclk_i),
    .frame_last_i(frame_last_i), .row_div_i(row_div_i),
    .row_en_o(row_en_o), .integ_o(integ_o), .fire_out_o(fire_out_o),
    .adc_cs_n_o(adc_cs_n_o), .row_clk_o(row_clk_o)
  );

  // {edge number, row_en, integ, fire_out, adc_cs_n} with frame_last = 199
  localparam logic [19:0] VEC [14] = '{
    {16'd1,   4'b0001}, {16'd99,  4'b0001}, {16'd100, 4'b1101}, {16'd124, 4'b1101},
    {16'd125, 4'b1010}, {16'd129, 4'b1010}, {16'd130, 4'b1000}, {16'd156, 4'b1000},
    {16'd157, 4'b1001}, {16'd199, 4'b1001}, {16'd200, 4'b0001}, {16'd201, 4'b0001},
    {16'd300, 4'b1101}, {16'd325, 4'b1010}
  };

  function automatic logic exp_row_clk(input int k, input int z);
    int zz;
    zz = (z == 0) ? 1 : z;
    return ((k / zz) % 2) == 1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d (edge %0d)", req, act, exp, edges);
    end
  endtask

  task automatic pulse(input int hi);
    sclk_i = 1'b1;
    repeat (hi) @(posedge clk);
    sclk_i = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    if (run_i) edges++;
  endtask

  task automatic set_run(input logic v);
    @(posedge clk);
    #1;
    run_i = v;
    edges = 0;
    repeat (2) @(posedge clk);
    #1;
  endtask

  function automatic int strobes();
    return {row_en_o, integ_o, fire_out_o, adc_cs_n_o};
  endfunction

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog act=0 exp=1");
    if (!done) begin
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cs_low;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 reset strobes", strobes(), 4'b0001);
    check("R1 reset row_clk", row_clk_o, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    pulse(4);
    pulse(4);
    check("R1 idle after edges with run low", {strobes(), row_clk_o}, 5'b00010);

    // R3 R4 R5 R6 R7 R8: table walk over two frames
    frame_last_i = 16'd199;
    row_div_i    = 16'd7;
    zdiv         = 7;
    set_run(1'b1);
    cs_low = 0;
    for (int i = 0; i < 14; i++) begin
      while (edges < int'(VEC[i][19:4])) begin
        pulse(4);
        if (edges <= 199 && !adc_cs_n_o) cs_low++;
      end
      check("R3/R4/R5/R6/R7 strobes", strobes(), int'(VEC[i][3:0]));
      check("R8 row_clk z=7", row_clk_o, exp_row_clk(edges, zdiv));
    end
    check("R6 chip select low cycles per frame", cs_low, 32);

    // R9: stop mid-frame (count 125, windows open)
    set_run(1'b0);
    check("R9 stop returns idle", {strobes(), row_clk_o}, 5'b00010);

    // R2: edges while stopped ignored; long high phase counts once
    pulse(4);
    pulse(4);
    pulse(4);
    check("R2 no change while stopped", {strobes(), row_clk_o}, 5'b00010);
    set_run(1'b1);
    pulse(40);
    while (edges < 99) pulse(4);
    check("R2 count 99 after long pulse", row_en_o, 0);
    pulse(4);
    check("R2 R9 row_en at 100 after restart", row_en_o, 1);

    // R7 truncated frame, R8 ratio zero
    set_run(1'b0);
    frame_last_i = 16'd104;
    row_div_i    = 16'd0;
    zdiv         = 0;
    set_run(1'b1);
    pulse(4);
    check("R8 z=0 first edge", row_clk_o, 1);
    pulse(4);
    check("R8 z=0 second edge", row_clk_o, 0);
    while (edges < 104) pulse(4);
    check("R3 R4 count 104", strobes(), 4'b1101);
    pulse(4);
    check("R7 wrap clears windows", strobes(), 4'b0001);
    while (edges < 205) pulse(4);
    check("R7 second short frame row_en", strobes(), 4'b1101);
    check("R8 z=0 parity", row_clk_o, exp_row_clk(edges, zdiv));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule